// File: doc/BRIEF.md
# Serial Timecode Link with CRC-8

This block sends the local time of day once per heartbeat period as a framed serial word on a single data line. On each rising edge of the heartbeat input it captures the 80-bit time (48-bit seconds above 32-bit nanoseconds), an 8-bit accuracy code and a lock decision. A gap of a set number of bit-clock periods follows. The block then drives a start bit. After the start bit it sends a 97-bit word: the lock bit, the time, the accuracy code and a CRC-8 over the first 89 of those bits. Between frames the line is held low.

The same block holds a matching receiver. After every heartbeat edge the receiver looks for a start bit on its serial input. It then shifts in the 97-bit word. It updates its time, lock and accuracy outputs, and pulses a valid strobe, only when the CRC check passes. The heartbeat and the bit clock are plain level inputs sampled by the system clock. The bit clock is expected to run at least 100 times faster than the heartbeat, which lies between 1 Hz and 8 kHz.

Top module: `tc_link`

## Requirements
- R1: Outside a frame, and from reset, `sdo_o` is low.
- R2: After a heartbeat rising edge, `sdo_o` stays low for the first GAP_BITS (default 2) bit-clock rising edges. The start bit is driven at the edge that follows them.
- R3: The start bit is high for exactly one bit-clock period. The lock bit follows it directly.
- R4: After the start bit the line carries 97 bits, most significant bit first: lock, time_i[79:0], acc_i[7:0], crc[7:0]. The line then returns low.
- R5: The time, accuracy and lock sent in a frame are the values present at the heartbeat rising edge. Later changes to the inputs do not alter the frame.
- R6: The CRC field is CRC-8 with polynomial x^8+x^5+x^4+1 (0x31), register initialised to zero, no reflection and no final inversion. It is computed over the 89 bits of lock, time and accuracy in the order they are sent.
- R7: The lock bit is 1 only if all of these hold: `locked_i` is high, the accuracy code lies in 32..48 (32 = within 25 ns, 48 = within 10 s), and the code is less than or equal to `thr_i`. Code 254 (unknown) and every other code outside 32..48 yield 0.
- R8: `sdo_o` changes only in the clock cycle that follows a bit-clock rising edge.
- R9: After a heartbeat edge the receiver takes the first 1 it samples on `sdi_i` at a bit-clock falling edge as the start bit. It then shifts in 97 bits. When the CRC over the received word leaves a zero remainder, it pulses `rx_valid_o` for one cycle and presents the received lock, time and accuracy.
- R10: A received word that fails the CRC produces no `rx_valid_o` pulse and leaves `rx_lock_o`, `rx_time_o` and `rx_acc_o` unchanged.
- R11: During reset `sdo_o`, `rx_valid_o`, `rx_lock_o`, `rx_time_o` and `rx_acc_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hb_i | input | 1 | Heartbeat level; its rising edge starts a frame |
| bclk_i | input | 1 | Bit clock level; data changes after its rising edge |
| time_i | input | 80 | Time of day: seconds [79:32], nanoseconds [31:0] |
| locked_i | input | 1 | Local clock reports lock |
| acc_i | input | 8 | Accuracy code |
| thr_i | input | 8 | Worst accuracy code still counted as locked |
| sdo_o | output | 1 | Serial timecode out |
| sdi_i | input | 1 | Serial timecode in, receiver side |
| rx_valid_o | output | 1 | One-cycle pulse: a word passed the CRC |
| rx_lock_o | output | 1 | Received lock bit |
| rx_time_o | output | 80 | Received time |
| rx_acc_o | output | 8 | Received accuracy code |

## Verification
The bench goes after the accuracy codes at the edges of the lock rule: 31, 32, 48 and 49, unknown 254, and codes equal to and one above the threshold. A wrong comparison there flips the lock bit, and because the lock bit feeds the CRC it also breaks the receiver's check. The inputs are scrambled two bit periods after each heartbeat edge. A design that reads the live inputs instead of the captured ones then sends a time that differs from the expected one. The bench sends frames with a single bit flipped on the receive path. A receiver that compares only part of the CRC, or that latches its outputs before the check, would then raise a strobe or change its outputs. The bench also samples the line just before every bit-clock rise and at the gap and idle periods. This catches an early or late start bit, a start bit that lasts two periods, and data that moves between bit-clock edges.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int unsigned CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h31;

  typedef enum logic [1:0] {TX_IDLE, TX_GAP, TX_SEND} tx_state_e;
  typedef enum logic [1:0] {RX_IDLE, RX_HUNT, RX_RECV} rx_state_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/tc_edge.sv
module tc_edge #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= sig_i;
  end

  assign rise_o = sig_i & ~q;
endmodule

// File: rtl/tc_tx.sv
module tc_tx
  import tc_pkg::*;
#(
  parameter int unsigned TIME_W   = 80,
  parameter int unsigned ACC_W    = 8,
  parameter int unsigned GAP_BITS = 2,
  parameter int unsigned ACC_MIN  = 32,
  parameter int unsigned ACC_MAX  = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hb_rise_i,
  input  logic              bclk_rise_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              locked_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [ACC_W-1:0]  thr_i,
  output logic              sdo_o
);
  localparam int unsigned PAY_W  = 1 + TIME_W + ACC_W;
  localparam int unsigned WORD_W = PAY_W + CRC_W;
  localparam int unsigned IDX_W  = $clog2(WORD_W + 2);
  localparam int unsigned GAP_W  = $clog2(GAP_BITS + 1);
  localparam logic [IDX_W-1:0] PAY_LAST  = IDX_W'(PAY_W);
  localparam logic [IDX_W-1:0] WORD_LAST = IDX_W'(WORD_W);
  localparam logic [GAP_W-1:0] GAP_LAST  = GAP_W'(GAP_BITS);

  tx_state_e          state;
  logic [PAY_W-1:0]   pay;
  logic [CRC_W-1:0]   crc;
  logic [IDX_W-1:0]   idx;
  logic [GAP_W-1:0]   gap_cnt;
  logic               lock_ok;

  assign lock_ok = locked_i && (acc_i >= ACC_W'(ACC_MIN)) &&
                   (acc_i <= ACC_W'(ACC_MAX)) && (acc_i <= thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= TX_IDLE;
      sdo_o   <= 1'b0;
      pay     <= '0;
      crc     <= '0;
      idx     <= '0;
      gap_cnt <= '0;
    end else begin
      unique case (state)
        TX_IDLE: if (hb_rise_i) begin
          pay     <= {lock_ok, time_i, acc_i};
          gap_cnt <= '0;
          state   <= TX_GAP;
        end
        TX_GAP: if (bclk_rise_i) begin
          if (gap_cnt == GAP_LAST) begin
            sdo_o <= 1'b1;
            crc   <= '0;
            idx   <= IDX_W'(1);
            state <= TX_SEND;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        TX_SEND: if (bclk_rise_i) begin
          if (idx <= PAY_LAST) begin
            sdo_o <= pay[PAY_W-1];
            pay   <= {pay[PAY_W-2:0], 1'b0};
            crc   <= crc_step(crc, pay[PAY_W-1]);
            idx   <= idx + 1'b1;
          end else if (idx <= WORD_LAST) begin
            sdo_o <= crc[CRC_W-1];
            crc   <= {crc[CRC_W-2:0], 1'b0};
            idx   <= idx + 1'b1;
          end else begin
            sdo_o <= 1'b0;
            state <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != TX_SEND) |-> !sdo_o);

  p_gap_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state) == TX_GAP && state == TX_SEND) |-> ($past(gap_cnt) == GAP_LAST && sdo_o));

  p_hold_between_edges_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bclk_rise_i |=> $stable(sdo_o));
endmodule

// File: rtl/tc_rx.sv
module tc_rx
  import tc_pkg::*;
#(
  parameter int unsigned TIME_W = 80,
  parameter int unsigned ACC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hb_rise_i,
  input  logic              bclk_fall_i,
  input  logic              sdi_i,
  output logic              rx_valid_o,
  output logic              rx_lock_o,
  output logic [TIME_W-1:0] rx_time_o,
  output logic [ACC_W-1:0]  rx_acc_o
);
  localparam int unsigned WORD_W = 1 + TIME_W + ACC_W + CRC_W;
  localparam int unsigned CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  rx_state_e          state;
  logic [WORD_W-2:0]  sh;
  logic [WORD_W-1:0]  word_nxt;
  logic [CRC_W-1:0]   crc, crc_nxt;
  logic [CNT_W-1:0]   cnt;

  assign word_nxt = {sh, sdi_i};
  assign crc_nxt  = crc_step(crc, sdi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= RX_IDLE;
      sh         <= '0;
      crc        <= '0;
      cnt        <= '0;
      rx_valid_o <= 1'b0;
      rx_lock_o  <= 1'b0;
      rx_time_o  <= '0;
      rx_acc_o   <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (hb_rise_i) begin
        state <= RX_HUNT;
      end else begin
        unique case (state)
          RX_IDLE: ;
          RX_HUNT: if (bclk_fall_i && sdi_i) begin
            cnt   <= '0;
            crc   <= '0;
            state <= RX_RECV;
          end
          RX_RECV: if (bclk_fall_i) begin
            sh  <= word_nxt[WORD_W-2:0];
            crc <= crc_nxt;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_LAST) begin
              state <= RX_IDLE;
              if (crc_nxt == '0) begin
                rx_valid_o <= 1'b1;
                rx_lock_o  <= word_nxt[WORD_W-1];
                rx_time_o  <= word_nxt[WORD_W-2 -: TIME_W];
                rx_acc_o   <= word_nxt[CRC_W +: ACC_W];
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_valid_after_word_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ($past(state) == RX_RECV && state == RX_IDLE));

  p_fields_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_valid_o |-> ($stable(rx_time_o) && $stable(rx_acc_o) && $stable(rx_lock_o)));
endmodule

// File: rtl/tc_link.sv
module tc_link #(
  parameter int unsigned TIME_W   = 80,
  parameter int unsigned ACC_W    = 8,
  parameter int unsigned GAP_BITS = 2,
  parameter int unsigned ACC_MIN  = 32,
  parameter int unsigned ACC_MAX  = 48
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hb_i,
  input  logic              bclk_i,
  input  logic [TIME_W-1:0] time_i,
  input  logic              locked_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [ACC_W-1:0]  thr_i,
  output logic              sdo_o,
  input  logic              sdi_i,
  output logic              rx_valid_o,
  output logic              rx_lock_o,
  output logic [TIME_W-1:0] rx_time_o,
  output logic [ACC_W-1:0]  rx_acc_o
);
  logic [2:0] rise;

  // bit 2 is the rise of the inverted bit clock, i.e. its falling edge
  tc_edge #(.W(3)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({~bclk_i, bclk_i, hb_i}),
    .rise_o(rise)
  );

  tc_tx #(
    .TIME_W(TIME_W), .ACC_W(ACC_W), .GAP_BITS(GAP_BITS),
    .ACC_MIN(ACC_MIN), .ACC_MAX(ACC_MAX)
  ) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hb_rise_i  (rise[0]),
    .bclk_rise_i(rise[1]),
    .time_i     (time_i),
    .locked_i   (locked_i),
    .acc_i      (acc_i),
    .thr_i      (thr_i),
    .sdo_o      (sdo_o)
  );

  tc_rx #(.TIME_W(TIME_W), .ACC_W(ACC_W)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hb_rise_i  (rise[0]),
    .bclk_fall_i(rise[2]),
    .sdi_i      (sdi_i),
    .rx_valid_o (rx_valid_o),
    .rx_lock_o  (rx_lock_o),
    .rx_time_o  (rx_time_o),
    .rx_acc_o   (rx_acc_o)
  );
endmodule

// File: tb/sim_tc_link.sv
`timescale 1ns/1ps
module sim_tc_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hb = 1'b0, bclk = 1'b0;
  logic [79:0] tod = '0;
  logic        locked = 1'b0;
  logic [7:0]  acc = '0, thr = '0;
  logic        sdo, sdi, inj = 1'b0;
  logic        rx_valid, rx_lock;
  logic [79:0] rx_time;
  logic [7:0]  rx_acc;
  int          checks = 0, errors = 0, vcnt = 0;
  bit          line [0:127];

  always #4 clk = ~clk;
  assign sdi = sdo ^ inj;

  tc_link u0 (
    .clk_i(clk), .rst_ni(rst_n), .hb_i(hb), .bclk_i(bclk), .time_i(tod),
    .locked_i(locked), .acc_i(acc), .thr_i(thr), .sdo_o(sdo), .sdi_i(sdi),
    .rx_valid_o(rx_valid), .rx_lock_o(rx_lock), .rx_time_o(rx_time), .rx_acc_o(rx_acc)
  );

  always @(negedge clk) if (rst_n && rx_valid) vcnt++;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit exp_lock(input bit l, input logic [7:0] a, input logic [7:0] t);
    return l && a >= 8'd32 && a <= 8'd48 && a <= t;
  endfunction

  function automatic logic [7:0] crc8(input logic [88:0] d);
    logic [7:0] r = '0;
    for (int i = 88; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = (r << 1) ^ 8'h31;
      else             r = r << 1;
    end
    return r;
  endfunction

  task automatic bit_period(output bit s_hold, output bit s_data);
    @(negedge clk) bclk = 1'b1; s_hold = sdo;
    @(negedge clk);
    @(negedge clk) bclk = 1'b0; s_data = sdo;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic [79:0] t, input bit l, input logic [7:0] a,
                           input logic [7:0] th, input int flip_p);
    logic [96:0] w, got;
    logic [88:0] pay;
    logic [79:0] prev_time;
    logic [7:0]  prev_acc;
    bit          prev_lock, h, d, last;
    int          hold_err;
    prev_time = rx_time; prev_acc = rx_acc; prev_lock = rx_lock;
    tod = t; locked = l; acc = a; thr = th;
    pay = {exp_lock(l, a, th), t, a};
    w   = {pay, crc8(pay)};
    vcnt = 0; hold_err = 0; last = sdo;
    @(negedge clk) hb = 1'b1;
    for (int p = 1; p <= 110; p++) begin
      if (p == flip_p) inj = 1'b1;
      bit_period(h, d);
      inj = 1'b0;
      if (h !== last) hold_err++;
      last = d; line[p] = d;
      if (p == 2) begin
        tod = {$urandom, $urandom, $urandom}; acc = 8'($urandom);
        locked = ~locked; thr = 8'($urandom);
      end
      if (p == 40) hb = 1'b0;
    end
    for (int k = 0; k < 97; k++) got[96-k] = line[4+k];
    chk(line[1] == 0 && line[2] == 0, "R2 gap low", 128'({line[1], line[2]}), 128'(0));
    chk(line[3] == 1 && line[4] == w[96], "R3 start bit then lock", 128'({line[3], line[4]}), 128'({1'b1, w[96]}));
    chk(got[96] == exp_lock(l, a, th), "R7 lock bit", 128'(got[96]), 128'(exp_lock(l, a, th)));
    chk(got[95:16] == t, "R5 captured time", 128'(got[95:16]), 128'(t));
    chk(got[7:0] == crc8(pay), "R6 crc field", 128'(got[7:0]), 128'(crc8(pay)));
    chk(got == w, "R4 frame word", 128'(got), 128'(w));
    begin
      bit idle_ok = 1;
      for (int p = 101; p <= 110; p++) if (line[p]) idle_ok = 0;
      chk(idle_ok, "R1 idle low after frame", 128'(idle_ok), 128'(1));
    end
    chk(hold_err == 0, "R8 line stable between bit edges", 128'(hold_err), 128'(0));
    if (flip_p < 0) begin
      chk(vcnt == 1, "R9 valid pulse count", 128'(vcnt), 128'(1));
      chk({rx_lock, rx_time, rx_acc} == w[96:8], "R9 received fields",
          128'({rx_lock, rx_time, rx_acc}), 128'(w[96:8]));
    end else begin
      chk(vcnt == 0, "R10 no valid on bad crc", 128'(vcnt), 128'(0));
      chk({rx_lock, rx_time, rx_acc} == {prev_lock, prev_time, prev_acc}, "R10 fields unchanged",
          128'({rx_lock, rx_time, rx_acc}), 128'({prev_lock, prev_time, prev_acc}));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    chk(sdo == 0 && rx_valid == 0 && rx_lock == 0 && rx_time == '0 && rx_acc == '0,
        "R11 reset state", 128'({sdo, rx_valid, rx_lock, rx_acc}), 128'(0));
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo == 0, "R1 idle after reset", 128'(sdo), 128'(0));
    // directed lock-rule corners (R7)
    run_frame(80'h0000_1234_5678_3B9A_C9FF, 1, 8'd40, 8'd40, -1);
    run_frame(80'hFFFF_FFFF_FFFF_0000_0000, 1, 8'd41, 8'd40, -1);
    run_frame(80'h0000_0000_0001_3B9A_C9FF, 1, 8'd254, 8'd255, -1);
    run_frame(80'h8000_0000_0000_0000_0001, 1, 8'd31, 8'd255, -1);
    run_frame(80'h0123_4567_89AB_CDEF_0123, 1, 8'd32, 8'd32, -1);
    run_frame(80'h0, 1, 8'd48, 8'd255, -1);
    run_frame(80'hFFFF_FFFF_FFFF_FFFF_FFFF, 1, 8'd49, 8'd255, -1);
    run_frame(80'h5555_AAAA_5555_AAAA_5555, 0, 8'd35, 8'd48, -1);
    // corrupted receive path (R10)
    run_frame(80'h0F0F_0F0F_0F0F_0F0F_0F0F, 1, 8'd36, 8'd40, 50);
    run_frame(80'h1111_2222_3333_4444_5555, 0, 8'd44, 8'd40, 100);
    run_frame(80'h0BAD_F00D_0BAD_F00D_0001, 1, 8'd33, 8'd40, -1);
    // random frames
    for (int n = 0; n < 12; n++) begin
      logic [7:0] ra;
      ra = ($urandom % 4 == 0) ? 8'($urandom) : 8'(32 + $urandom % 17);
      run_frame({$urandom, $urandom, $urandom}, 1'($urandom), ra, 8'(32 + $urandom % 17),
                (n % 5 == 4) ? int'(4 + $urandom % 97) : -1);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule